// File: doc/BRIEF.md
# Batched Register Access Command Engine

This block is the controller-side executor for power-control register access commands that arrive through a mailbox. A command has a message byte, a sub-command, a size field and a 16-byte request buffer. The engine decodes the command and checks it. It then works through a local byte-wide register file addressed by 16-bit addresses, handling one entry per clock. At the end it presents a 16-byte response buffer together with a one-cycle done pulse and an error flag.

Three sub-commands exist: a batched read, a batched write, and a masked read-modify-write. In every request the addresses come first, each as two bytes with the low byte first, packed from byte 0. A batched write follows its addresses with one data byte per address. A read-modify-write follows its single address with a data byte and then a mask byte. The command is checked in full before anything is executed, so a malformed command or an address outside the register file leaves the register file untouched.

Top module: `regacc_engine`

## Requirements
- R1: After reset, busy, done and err are 0, every response byte is 0, and every register holds 0.
- R2: Message byte 0xFF with sub-command 1 is a batched read of n addresses. It is accepted only when size = 2n. Address k occupies request bytes 2k (low) and 2k+1 (high). Response byte k returns the value at address k, and every other response byte is 0.
- R3: Message byte 0xFF with sub-command 0 is a batched write of n entries. It is accepted only when size = 3n. Address k is laid out as in R2, and its data byte is request byte 2n+k. The response is all zero.
- R4: Message byte 0xFF with sub-command 2 is a masked update. It is accepted only when size = 4. It uses the address in bytes 0–1, the data in byte 2 and the mask in byte 3. Bits whose mask bit is 1 take the data bit, and the other bits keep their old value. Response byte 0 holds the new register value, and the other response bytes are 0.
- R5: An accepted command of n entries keeps busy high for n cycles. Done pulses high for exactly one cycle, beginning at the n-th rising edge after the accepting edge, with err = 0.
- R6: A message byte other than 0xFF, a sub-command above 2, an entry count of 0 or above 5, or a size that does not fit the sub-command gives done and err = 1 from the accepting edge itself. No register changes, and the response is all zero.
- R7: If any address of a command is at or beyond the register count, the command ends as in R6 with no register written. This applies to in-range entries that come before the bad address.
- R8: While busy is high, req_valid and the request fields are ignored.
- R9: Every accepted command clears the previous response and error. A later good command after an error reports err = 0.
- R10: Batched write entries are applied in request order, so when one address appears twice its last data byte remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when not busy |
| req_cmd | input | 8 | Message byte |
| req_sub | input | 4 | Sub-command |
| req_size | input | 8 | Payload size in bytes |
| req_data | input | 128 | Request buffer, byte k at bits 8k+7:8k |
| busy | output | 1 | Command executing |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status of the last command |
| rsp_data | output | 128 | Response buffer, byte k at bits 8k+7:8k |

## Verification
The assertions assume that req_valid and the request fields are settled before each rising edge. They also assume that the register file is reached only through commands that the decoder has already approved. Neither assumption constrains what a request may contain. The stimulus drives every input at the falling edge. It holds a request for exactly one edge, except in the busy-window case, where junk is held on purpose while the engine runs. The random commands cover all valid shapes, malformed sizes and sub-commands, foreign message bytes and out-of-range addresses, and the latency check covers every case.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  localparam logic [7:0] PWR_MSG = 8'hFF;
  localparam logic [3:0] SUB_WR  = 4'd0;
  localparam logic [3:0] SUB_RD  = 4'd1;
  localparam logic [3:0] SUB_RMW = 4'd2;

  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} eng_state_e;

  // Number of entries implied by sub-command and size; 0 means malformed.
  function automatic logic [7:0] entry_count(logic [3:0] sub, logic [7:0] size, int max_ent);
    logic [7:0] n;
    n = 8'd0;
    if (sub == SUB_RD) begin
      if (size != 8'd0 && !size[0] && size <= 8'(2 * max_ent)) n = size >> 1;
    end else if (sub == SUB_WR) begin
      if (size != 8'd0 && (size % 8'd3) == 8'd0 && size <= 8'(3 * max_ent)) n = size / 8'd3;
    end else if (sub == SUB_RMW) begin
      if (size == 8'd4) n = 8'd1;
    end
    return n;
  endfunction

  // Bits with mask 1 take the new value, the others keep the old.
  function automatic logic [7:0] masked_merge(logic [7:0] old_v, logic [7:0] new_v, logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/regacc_decode.sv
module regacc_decode
  import regacc_pkg::*;
#(
  parameter int MAX_ENT   = 5,
  parameter int REG_COUNT = 32,
  localparam int CW       = $clog2(MAX_ENT + 1)
) (
  input  logic [7:0]             cmd,
  input  logic [3:0]             sub,
  input  logic [7:0]             size,
  input  logic [16*MAX_ENT-1:0]  addr_bytes,
  output logic                   ok,
  output logic [CW-1:0]          count
);

  logic [7:0]         raw_cnt;
  logic [MAX_ENT-1:0] addr_bad;

  assign raw_cnt = entry_count(sub, size, MAX_ENT);
  assign count   = CW'(raw_cnt);

  for (genvar k = 0; k < MAX_ENT; k++) begin : g_addr
    logic [15:0] a;
    assign a           = addr_bytes[16*k +: 16];
    assign addr_bad[k] = (8'(k) < raw_cnt) && (32'(a) >= REG_COUNT);
  end

  assign ok = (cmd == PWR_MSG) && (raw_cnt != 8'd0) && (addr_bad == '0);

endmodule

// File: rtl/regacc_regfile.sv
module regacc_regfile #(
  parameter int REG_COUNT = 32,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          mem[i] <= 8'd0;
      else if (we && waddr == AW'(i))      mem[i] <= wdata;
    end

    // R7
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == AW'(i)) |=> $stable(mem[i]));
  end

  assign rdata = mem[raddr];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/regacc_engine.sv
module regacc_engine
  import regacc_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int MAX_ENT   = 5,
  parameter int REG_COUNT = 32,
  localparam int CW       = $clog2(MAX_ENT + 1),
  localparam int AW       = $clog2(REG_COUNT),
  localparam int BW       = $clog2(BUF_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [7:0]             req_cmd,
  input  logic [3:0]             req_sub,
  input  logic [7:0]             req_size,
  input  logic [8*BUF_BYTES-1:0] req_data,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [8*BUF_BYTES-1:0] rsp_data
);

  eng_state_e                  state;
  logic [BUF_BYTES-1:0][7:0]   buf_q;
  logic [BUF_BYTES-1:0][7:0]   rsp_q;
  logic [3:0]                  sub_q;
  logic [CW-1:0]               cnt_q;
  logic [CW-1:0]               idx;

  logic                        dec_ok;
  logic [CW-1:0]               dec_cnt;
  logic                        accept;
  logic                        last_entry;
  logic [BW-1:0]               a_lo, a_hi, wpos;
  logic                        rf_we;
  logic [AW-1:0]               rf_addr;
  logic [7:0]                  rf_rdata, rf_wdata;

  regacc_decode #(.MAX_ENT(MAX_ENT), .REG_COUNT(REG_COUNT)) u_dec (
    .cmd        (req_cmd),
    .sub        (req_sub),
    .size       (req_size),
    .addr_bytes (req_data[16*MAX_ENT-1:0]),
    .ok         (dec_ok),
    .count      (dec_cnt)
  );

  assign accept     = req_valid && (state == ST_IDLE);
  assign busy       = (state == ST_RUN);
  assign last_entry = (idx == cnt_q - CW'(1));

  assign a_lo    = BW'({idx, 1'b0});
  assign a_hi    = a_lo + BW'(1);
  assign wpos    = BW'({cnt_q, 1'b0}) + BW'(idx);
  assign rf_addr = AW'({buf_q[a_hi], buf_q[a_lo]});

  assign rf_we    = busy && (sub_q != SUB_RD);
  assign rf_wdata = (sub_q == SUB_RMW) ? masked_merge(rf_rdata, buf_q[2], buf_q[3])
                                       : buf_q[wpos];

  regacc_regfile #(.REG_COUNT(REG_COUNT)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_addr),
    .wdata (rf_wdata),
    .raddr (rf_addr),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      buf_q <= '0;
      rsp_q <= '0;
      sub_q <= '0;
      cnt_q <= '0;
      idx   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            buf_q <= req_data;
            sub_q <= req_sub;
            cnt_q <= dec_cnt;
            idx   <= '0;
            rsp_q <= '0;
            if (dec_ok) begin
              state <= ST_RUN;
              err   <= 1'b0;
            end else begin
              done  <= 1'b1;
              err   <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (sub_q == SUB_RD)  rsp_q[idx] <= rf_rdata;
          if (sub_q == SUB_RMW) rsp_q[0]   <= rf_wdata;
          if (last_entry) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            idx <= idx + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_data = rsp_q;

  // R6
  bad_cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !dec_ok |=> done && err && !busy);

  // R5
  good_cmd_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_ok |=> busy && !done && !err);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx < cnt_q));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(buf_q) && $stable(sub_q) && $stable(cnt_q));

endmodule

// File: tb/tb_regacc_engine.sv
`timescale 1ns/1ps
module tb_regacc_engine;

  localparam int RC = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [7:0]   req_cmd = '0;
  logic [3:0]   req_sub = '0;
  logic [7:0]   req_size = '0;
  logic [127:0] req_data = '0;
  logic         busy, done, err;
  logic [127:0] rsp_data;

  regacc_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_sub(req_sub), .req_size(req_size), .req_data(req_data),
    .busy(busy), .done(done), .err(err), .rsp_data(rsp_data)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [RC];

  task automatic check(string rq, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bb(logic [127:0] b, int k);
    return b[8*k +: 8];
  endfunction

  // Independent reference: computes response, error and latency, updates model.
  task automatic model_cmd(input logic [7:0] cmd, input logic [3:0] sub, input logic [7:0] size,
                           input logic [127:0] b, output logic [127:0] rsp,
                           output logic e, output int lat);
    int n = 0;
    logic bad = 0;
    rsp = '0;
    if (cmd != 8'hFF || sub > 2) bad = 1;
    else begin
      for (int k = 1; k <= 5; k++) begin
        if (sub == 1 && size == 8'(2*k)) n = k;
        if (sub == 0 && size == 8'(3*k)) n = k;
      end
      if (sub == 2 && size == 8'd4) n = 1;
      if (n == 0) bad = 1;
      for (int k = 0; k < n; k++)
        if ({bb(b, 2*k+1), bb(b, 2*k)} >= 16'(RC)) bad = 1;
    end
    e = bad;
    lat = bad ? 0 : n;
    if (!bad) begin
      for (int k = 0; k < n; k++) begin
        int a = int'({bb(b, 2*k+1), bb(b, 2*k)});
        if (sub == 1) rsp[8*k +: 8] = model[a];
        else if (sub == 0) model[a] = bb(b, 2*n + k);
        else begin
          logic [7:0] nv;
          for (int j = 0; j < 8; j++) nv[j] = bb(b, 3)[j] ? bb(b, 2)[j] : model[a][j];
          model[a] = nv;
          rsp[7:0] = nv;
        end
      end
    end
  endtask

  task automatic send(input logic [7:0] cmd, input logic [3:0] sub, input logic [7:0] size,
                      input logic [127:0] b, output logic [127:0] rsp, output logic e,
                      output int lat);
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_sub = sub; req_size = size; req_data = b;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rsp = rsp_data;
    e = err;
  endtask

  task automatic do_cmd(string rq, input logic [7:0] cmd, input logic [3:0] sub,
                        input logic [7:0] size, input logic [127:0] b);
    logic [127:0] r, er;
    logic e, ee;
    int lat, el;
    model_cmd(cmd, sub, size, b, er, ee, el);
    send(cmd, sub, size, b, r, e, lat);
    check(rq, "err", 128'(e), 128'(ee));
    check(rq, "rsp", r, er);
    check("R5", "latency", 128'(lat), 128'(el));
  endtask

  function automatic logic [127:0] addr_list(int a0, int a1, int a2, int a3, int a4);
    logic [127:0] b = '0;
    b[15:0] = 16'(a0); b[31:16] = 16'(a1); b[47:32] = 16'(a2);
    b[63:48] = 16'(a3); b[79:64] = 16'(a4);
    return b;
  endfunction

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [127:0] b, r;
    logic e;
    int lat;
    void'($urandom(32'd2024));
    for (int i = 0; i < RC; i++) model[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1", "busy", 128'(busy), 0);
    check("R1", "done", 128'(done), 0);
    check("R1", "err", 128'(err), 0);
    check("R1", "rsp", rsp_data, 0);
    for (int a = 0; a < RC; a += 5)
      do_cmd("R1", 8'hFF, 4'd1, 8'd10, addr_list(a, (a+1)%RC, (a+2)%RC, (a+3)%RC, (a+4)%RC));

    // R3 write five then R2 read back in different order
    b = addr_list(1, 2, 3, 4, 5);
    b[87:80] = 8'h11; b[95:88] = 8'h22; b[103:96] = 8'h33; b[111:104] = 8'h44; b[119:112] = 8'h55;
    do_cmd("R3", 8'hFF, 4'd0, 8'd15, b);
    do_cmd("R2", 8'hFF, 4'd1, 8'd6, addr_list(5, 3, 1, 0, 0));
    check("R2", "byte2 literal", 128'(rsp_data[23:16]), 128'(8'h11));

    // R10 duplicate address: last data wins
    b = addr_list(7, 7, 0, 0, 0);
    b[39:32] = 8'hAB; b[47:40] = 8'hCD;
    do_cmd("R10", 8'hFF, 4'd0, 8'd6, b);
    do_cmd("R10", 8'hFF, 4'd1, 8'd2, addr_list(7, 0, 0, 0, 0));
    check("R10", "dup value", 128'(rsp_data[7:0]), 128'(8'hCD));

    // R4 masked update
    b = addr_list(9, 0, 0, 0, 0); b[23:16] = 8'hA5;
    do_cmd("R3", 8'hFF, 4'd0, 8'd3, b);
    b = addr_list(9, 0, 0, 0, 0); b[23:16] = 8'h0F; b[31:24] = 8'h3C;
    do_cmd("R4", 8'hFF, 4'd2, 8'd4, b);
    check("R4", "merged literal", rsp_data, 128'(8'h8D));

    // R7 out-of-range third entry: earlier entries not written
    b = addr_list(1, 2, 16'h0100, 0, 0);
    b[55:48] = 8'hEE; b[63:56] = 8'hEE; b[71:64] = 8'hEE;
    do_cmd("R7", 8'hFF, 4'd0, 8'd9, b);
    do_cmd("R7", 8'hFF, 4'd1, 8'd4, addr_list(1, 2, 0, 0, 0));
    check("R7", "reg1 kept", 128'(rsp_data[7:0]), 128'(8'h11));

    // R6 count above 5, and R9 response cleared by the errored command
    do_cmd("R6", 8'hFF, 4'd1, 8'd12, addr_list(1, 2, 3, 4, 5));
    check("R9", "rsp cleared", rsp_data, 0);
    do_cmd("R6", 8'h7E, 4'd1, 8'd2, addr_list(1, 0, 0, 0, 0));
    do_cmd("R6", 8'hFF, 4'd2, 8'd3, addr_list(1, 0, 0, 0, 0));
    do_cmd("R9", 8'hFF, 4'd1, 8'd2, addr_list(1, 0, 0, 0, 0));
    check("R9", "err cleared", 128'(err), 0);

    // R8 junk request held while busy
    begin
      logic [127:0] er;
      logic ee;
      int el;
      b = addr_list(10, 11, 12, 13, 14);
      b[119:80] = 40'h5A_4B_3C_2D_1E;
      model_cmd(8'hFF, 4'd0, 8'd15, b, er, ee, el);
      @(negedge clk);
      req_valid = 1; req_cmd = 8'hFF; req_sub = 4'd0; req_size = 8'd15; req_data = b;
      @(posedge clk);
      @(negedge clk);
      req_size = 8'd3; req_data = addr_list(20, 16'h0077, 0, 0, 0);
      req_data[23:16] = 8'h77;
      check("R8", "busy", 128'(busy), 1);
      repeat (3) @(negedge clk);
      req_valid = 0;
      lat = 3;
      while (!done && lat < 50) begin @(negedge clk); lat++; end
      check("R8", "latency", 128'(lat), 128'(el));
      check("R8", "err", 128'(err), 0);
      do_cmd("R8", 8'hFF, 4'd1, 8'd4, addr_list(20, 12, 0, 0, 0));
      check("R8", "reg12 literal", 128'(rsp_data[15:8]), 128'(8'h3C));
    end

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int kind = int'($urandom_range(0, 19));
      int n = int'($urandom_range(1, 5));
      logic [7:0] cmd = 8'hFF;
      logic [3:0] sub;
      logic [7:0] size;
      string rq;
      b = {$urandom, $urandom, $urandom, $urandom};
      for (int k = 0; k < 5; k++) begin
        int a = ($urandom_range(0, 14) == 0) ? RC + int'($urandom_range(0, 300)) : int'($urandom_range(0, RC-1));
        b[16*k +: 16] = 16'(a);
      end
      if (kind < 8)       begin sub = 1; size = 8'(2*n); rq = "R2"; end
      else if (kind < 15) begin sub = 0; size = 8'(3*n); rq = "R3"; end
      else if (kind < 18) begin sub = 2; size = 8'd4;    rq = "R4"; end
      else begin
        rq = "R6";
        sub = 4'($urandom_range(0, 15));
        size = 8'($urandom_range(0, 18));
        if ($urandom_range(0, 1) == 1) cmd = 8'($urandom_range(0, 254));
      end
      do_cmd(rq, cmd, sub, size, b);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule